// File: doc/BRIEF.md
# Acknowledge Wait Controller with Timeout

This block is a small control state machine that guards a single handshake. From idle, a start request moves it into a holding state. There it waits for an acknowledge from a partner block. It leaves the holding state for a one-cycle completion state on whichever comes first: the acknowledge, or a fixed count of holding cycles. After the completion cycle it drops back to idle.

The current state is visible as a two-bit code. Two one-cycle flags report the cause of each exit, so the surrounding logic can tell a real handshake from a timeout. An acknowledge that is high in the same cycle the start request is accepted is remembered, and it causes the exit even if it is gone by the next cycle. Concurrent assertions inside the control logic check each dwell and exit rule separately.

Top module: `wait_gate`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) puts the state code to idle (2'b00) and both exit flags low on the following cycle, including when reset arrives mid-wait.
- R2: In idle, a sampled `startReq` makes the state code hold (2'b01) one cycle later. `ackIn` alone has no effect in idle. `startReq` has no effect while holding or completing: it neither restarts nor lengthens the wait.
- R3: While holding, with `ackIn` low, no remembered entry acknowledge and fewer than `TIMEOUT_CYCLES` holding cycles spent, the state stays hold.
- R4: When `ackIn` is sampled high in a holding cycle, the state code is done (2'b10) one cycle later and `ackPulse` is high in that done cycle.
- R5: With no acknowledge, the wait lasts exactly `TIMEOUT_CYCLES` holding cycles (100 by default), never fewer. The next cycle is done with `timeoutPulse` high.
- R6: An `ackIn` that is high in the idle cycle where `startReq` is accepted is honoured: the wait ends after one holding cycle with `ackPulse`, even if `ackIn` is low during that holding cycle.
- R7: If `ackIn` is sampled high in the last allowed holding cycle, acknowledge wins: only `ackPulse` is raised, never both flags.
- R8: The done state lasts exactly one cycle and is followed by idle. Each exit flag is high only in the done cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Request to begin a wait, sampled in idle |
| ackIn | input | 1 | Acknowledge from the partner block |
| stateOut | output | 2 | State code: 00 idle, 01 hold, 10 done |
| ackPulse | output | 1 | One-cycle flag: the wait ended by acknowledge |
| timeoutPulse | output | 1 | One-cycle flag: the wait ended by timeout |

## Verification
The bench builds the block with `TIMEOUT_CYCLES` at its default of 100. This makes the real boundary reachable: an acknowledge on holding cycle 98, a collision with the timeout on cycle 99, and an exit without acknowledge after exactly 100 holding cycles. A behavioural model counts holding cycles independently and is compared with the state code and both flags on every clock. Each scenario also measures the length of the wait at the ports. The scenarios cover an acknowledge that is present only at entry, a start request held high through a whole wait, and a reset that arrives mid-wait.

// File: rtl/wait_gate_pkg.sv
package wait_gate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_HOLD = 2'b01,
    ST_DONE = 2'b10
  } gateState_t;

  // Strobes from the control FSM to the dwell datapath.
  typedef struct packed {
    logic cntClear;   // wait is being entered
    logic cntStep;    // one more holding cycle
    logic earlyLoad;  // capture acknowledge seen at entry
  } dwellCmd_t;

endpackage

// File: rtl/wait_gate_dwell.sv
module wait_gate_dwell
  import wait_gate_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 100
) (
  input  logic      clk,
  input  logic      rst,
  input  dwellCmd_t cmd,
  input  logic      ackIn,
  output logic      timeoutHit,
  output logic      earlyAck
);

  localparam int CNT_W = (TIMEOUT_CYCLES > 1) ? $clog2(TIMEOUT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(TIMEOUT_CYCLES - 1);

  logic [CNT_W-1:0] dwellCnt;
  logic             earlyFlag;

  always_ff @(posedge clk) begin
    if (rst) begin
      dwellCnt  <= '0;
      earlyFlag <= 1'b0;
    end else begin
      if (cmd.cntClear) begin
        dwellCnt <= '0;
      end else if (cmd.cntStep && (dwellCnt != LAST_IDX)) begin
        dwellCnt <= dwellCnt + 1'b1;
      end
      if (cmd.earlyLoad) begin
        earlyFlag <= ackIn;
      end
    end
  end

  assign timeoutHit = (dwellCnt == LAST_IDX);
  assign earlyAck   = earlyFlag;

endmodule

// File: rtl/wait_gate_ctrl.sv
module wait_gate_ctrl
  import wait_gate_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       startReq,
  input  logic       ackIn,
  input  logic       timeoutHit,
  input  logic       earlyAck,
  output gateState_t state,
  output logic       ackPulse,
  output logic       timeoutPulse,
  output dwellCmd_t  cmd
);

  gateState_t nextState;
  logic       ackNow;

  assign ackNow = ackIn | earlyAck;

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE: if (startReq) nextState = ST_HOLD;
      ST_HOLD: if (ackNow || timeoutHit) nextState = ST_DONE;
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_comb begin
    cmd.cntClear  = (state == ST_IDLE) && startReq;
    cmd.cntStep   = (state == ST_HOLD);
    cmd.earlyLoad = (state == ST_IDLE) && startReq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      ackPulse     <= 1'b0;
      timeoutPulse <= 1'b0;
    end else begin
      state        <= nextState;
      ackPulse     <= (state == ST_HOLD) && ackNow;
      timeoutPulse <= (state == ST_HOLD) && !ackNow && timeoutHit;
    end
  end

  // ---------------------------------------------------------------
  // Checks. chkDwell counts holding cycles independently of the
  // datapath counter.
  // ---------------------------------------------------------------
  int unsigned chkDwell;
  always_ff @(posedge clk) begin
    if (rst || state == ST_IDLE) chkDwell <= 0;
    else if (state == ST_HOLD)   chkDwell <= chkDwell + 1;
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (state == ST_IDLE && !ackPulse && !timeoutPulse));

  assert_start_enters_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && startReq) |=> state == ST_HOLD);

  assert_idle_stays_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && !startReq) |=> state == ST_IDLE);

  assert_hold_dwell_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && !ackIn && !earlyAck && !timeoutHit) |=> state == ST_HOLD);

  assert_ack_exit_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && ackIn) |=> (state == ST_DONE && ackPulse));

  assert_timeout_exit_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && timeoutHit && !ackIn && !earlyAck)
      |=> (state == ST_DONE && timeoutPulse));

  assert_timeout_length_R5: assert property (@(posedge clk) disable iff (rst)
    timeoutPulse |-> chkDwell == TIMEOUT_CYCLES);

  assert_entry_ack_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && startReq && ackIn) |=> ##1 (state == ST_DONE && ackPulse));

  assert_ack_priority_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && timeoutHit && ackIn) |=> (ackPulse && !timeoutPulse));

  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ackPulse, timeoutPulse}));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    state == ST_DONE |=> state == ST_IDLE);

  assert_flag_in_done_R8: assert property (@(posedge clk) disable iff (rst)
    (ackPulse || timeoutPulse) |-> state == ST_DONE);

endmodule

// File: rtl/wait_gate.sv
module wait_gate
  import wait_gate_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       startReq,
  input  logic       ackIn,
  output logic [1:0] stateOut,
  output logic       ackPulse,
  output logic       timeoutPulse
);

  gateState_t state;
  dwellCmd_t  cmd;
  logic       timeoutHit;
  logic       earlyAck;

  wait_gate_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_ctrl (
    .clk          (clk),
    .rst          (rst),
    .startReq     (startReq),
    .ackIn        (ackIn),
    .timeoutHit   (timeoutHit),
    .earlyAck     (earlyAck),
    .state        (state),
    .ackPulse     (ackPulse),
    .timeoutPulse (timeoutPulse),
    .cmd          (cmd)
  );

  wait_gate_dwell #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_dwell (
    .clk        (clk),
    .rst        (rst),
    .cmd        (cmd),
    .ackIn      (ackIn),
    .timeoutHit (timeoutHit),
    .earlyAck   (earlyAck)
  );

  assign stateOut = state;

endmodule

// File: tb/test_wait_gate.sv
`timescale 1ns/1ps
module test_wait_gate;

  localparam int TMO = 100;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       startReq = 1'b0;
  logic       ackIn = 1'b0;
  logic [1:0] stateOut;
  logic       ackPulse;
  logic       timeoutPulse;

  always #4 clk = ~clk;  // 125 MHz

  wait_gate #(.TIMEOUT_CYCLES(TMO)) i_wait_gate (
    .clk          (clk),
    .rst          (rst),
    .startReq     (startReq),
    .ackIn        (ackIn),
    .stateOut     (stateOut),
    .ackPulse     (ackPulse),
    .timeoutPulse (timeoutPulse)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // Behavioural reference: state code 0 idle, 1 hold, 2 done.
  int refSt = 0;
  int refCnt = 0;
  bit refEarly = 0, refAck = 0, refTo = 0, live = 0;

  always @(posedge clk) begin
    live <= 1'b1;
    if (rst) begin
      refSt <= 0; refCnt <= 0; refEarly <= 0; refAck <= 0; refTo <= 0;
    end else begin
      refAck <= 0;
      refTo  <= 0;
      case (refSt)
        0: if (startReq) begin refSt <= 1; refCnt <= 0; refEarly <= ackIn; end
        1: if (ackIn || refEarly) begin refSt <= 2; refAck <= 1; end
           else if (refCnt == TMO - 1) begin refSt <= 2; refTo <= 1; end
           else refCnt <= refCnt + 1;
        default: refSt <= 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (live) begin
      string tag;
      if (refAck)          tag = "R4";
      else if (refTo)      tag = "R5";
      else if (refSt == 1) tag = "R3";
      else if (refSt == 2) tag = "R8";
      else                 tag = "R2";
      check(tag, stateOut, refSt, "state code vs model");
      check(tag, ackPulse, refAck, "ack flag vs model");
      check(tag, timeoutPulse, refTo, "timeout flag vs model");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      checks++;
      $display("FAIL R8 watchdog: cycles=%0d expected below %0d", cyc, 20000);
      finishRun();
    end
  end

  // One wait: ackAt is the holding cycle index with ackIn high (-1: none).
  task automatic runWait(input int ackAt, input bit ackAtEntry, input bit keepStart,
                         input int expLen, input bit expAck, input string tag);
    int k;
    @(negedge clk);
    startReq = 1'b1;
    ackIn    = ackAtEntry;
    @(negedge clk);
    startReq = keepStart;
    k = 0;
    while (stateOut == 2'b01 && k < TMO + 5) begin
      ackIn = (k == ackAt);
      @(negedge clk);
      k++;
    end
    check(tag, k, expLen, "holding cycles");
    check(tag, stateOut, 2, "exit state");
    check(tag, ackPulse, expAck, "ack flag at exit");
    check(tag, timeoutPulse, !expAck, "timeout flag at exit");
    ackIn    = 1'b0;
    startReq = 1'b0;
    @(negedge clk);
    check("R8", stateOut, 0, "idle after done");
    check("R8", ackPulse | timeoutPulse, 0, "flags one cycle only");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", stateOut, 0, "reset state");
    check("R1", ackPulse | timeoutPulse, 0, "reset flags");
    rst = 1'b0;

    // R2: acknowledge alone in idle does nothing
    ackIn = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R2", stateOut, 0, "idle with ack only");
    end
    ackIn = 1'b0;

    runWait(0,  1'b0, 1'b0, 1,   1'b1, "R4");       // ack on first holding cycle
    runWait(-1, 1'b1, 1'b0, 1,   1'b1, "R6");       // ack only at entry
    runWait(50, 1'b0, 1'b0, 51,  1'b1, "R4");       // ack mid-wait
    runWait(98, 1'b0, 1'b0, 99,  1'b1, "R4");       // ack just before limit
    runWait(99, 1'b0, 1'b0, 100, 1'b1, "R7");       // ack collides with timeout
    runWait(-1, 1'b0, 1'b0, 100, 1'b0, "R5");       // no ack at all
    runWait(-1, 1'b0, 1'b1, 100, 1'b0, "R2");       // start held through wait

    // R1: reset in the middle of a wait
    @(negedge clk);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", stateOut, 0, "reset mid-wait");
    check("R1", ackPulse | timeoutPulse, 0, "reset mid-wait flags");
    rst = 1'b0;
    runWait(-1, 1'b0, 1'b0, 100, 1'b0, "R5");       // full wait after reset

    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule